// File: doc/BRIEF.md
# Banked Register File with Working-Group Pointer

This block is the on-chip byte register file of a small 8-bit controller. General-purpose storage, control registers and the I/O port registers share one 8-bit address space. Software reaches the port pins with ordinary register reads and writes, so there is no separate I/O path.

Any access can name a register by a full 8-bit address. It can also use a short 4-bit working address, which a programmable group pointer widens to a full address. The pointer lives in the file itself. Changing it switches the active 16-register group in one write, which makes context switches cheap.

The file has two combinational read ports and one write port. A separate operation port tests, sets, clears or flips a single bit in place. The same port increments or decrements a 16-bit value held in an aligned register pair.

Top module: `regbank_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored location is cleared to 0x00. This clears the group pointer and the port output latches, so `port_out` becomes 0.
- R2: A write to any address in 0x04..0x7F or 0xF0..0xFF stores `wr_data`. From the next cycle on, both read ports return the stored byte until that location is changed again.
- R3: Addresses 0x80..0xDF hold nothing. They read 0x00, including in the cycle they are written, and writes to them change no other location.
- R4: When an access's short flag is 1, its address bits [3:0] are a working address. The effective address is {pointer[7:4], addr[3:0]}. A full address whose upper nibble is 0xE expands the same way. This applies to both read ports, the write port and the operation port.
- R5: The group pointer is the register at 0xFD and is written like any other register. A new pointer value affects address expansion from the cycle after the write, and reads of 0xFD return it.
- R6: Port register n (address n, n = 0..3) reads the pin byte `port_in[8n+7:8n]`, also in a cycle that writes it. A write to it updates the output latch `port_out[8n+7:8n]` at the clock edge. With no write and no operation, `port_out` holds its value.
- R7: A read of a storage location (not a port register) that the write port writes in the same cycle returns `wr_data` in that cycle.
- R8: Bit operations use `op_code` 1 = test, 2 = set, 3 = clear and 4 = complement, on bit `op_bit` of the register at `op_addr`. Bit 0 is the least significant bit. `op_flag` is the prior value of that bit, in the same cycle. Set, clear and complement update the register at the clock edge.
- R9: `op_code` 5 increments and 6 decrements the 16-bit word in a register pair. The even address holds the high byte and the odd address holds the low byte, and `op_addr[0]` is ignored. The result wraps modulo 65536 and is stored at the clock edge. `op_flag` is 1 exactly when the result is 0x0000.
- R10: When the write port and the operation port change the same byte in one cycle, the write port's value is stored.
- R11: Operations on a port register read and modify its output latch, not the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_addr | input | 8 | Read port A address |
| rd_a_short | input | 1 | Read port A uses a 4-bit working address |
| rd_a_data | output | 8 | Read port A data (combinational) |
| rd_b_addr | input | 8 | Read port B address |
| rd_b_short | input | 1 | Read port B uses a 4-bit working address |
| rd_b_data | output | 8 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_short | input | 1 | Write uses a 4-bit working address |
| wr_data | input | 8 | Write data |
| op_code | input | 3 | Operation: 0 none, 1 test, 2 set, 3 clear, 4 complement, 5 increment word, 6 decrement word |
| op_addr | input | 8 | Operation target address |
| op_short | input | 1 | Operation uses a 4-bit working address |
| op_bit | input | 3 | Bit index for bit operations |
| op_flag | output | 1 | Prior bit value, or zero flag of a word result |
| port_in | input | 32 | Pin-side inputs of the four port registers |
| port_out | output | 32 | Output latches of the four port registers |

## Verification
The properties watch only full-address accesses, where the target is known without modelling the pointer. They also assume that `op_code` holds only the values 0 to 6. The write-then-read property further assumes that no operation modifies the same byte in the cycle between the write and the read. The stimulus follows these rules: unused operation codes are never driven, and bit or word operations never target a location that is being checked for a held write. Working-address accesses are checked only by the bench. It sets the pointer through 0xFD and then compares the expanded locations with their full-address aliases.

// File: rtl/regbank_pkg.sv
// Shared constants and the operation encoding for the banked register file.
package regbank_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_TEST = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_CPL  = 3'd4,
        OP_INCW = 3'd5,
        OP_DECW = 3'd6
    } bitop_e;
endpackage

// File: rtl/regbank_xlat.sv
// Address translator: expands a short or working-group address through the
// group pointer, then maps the physical address to a dense storage index.
// Assumes the low region starts at 0 and that the gap between the regions
// (HI_BASE - LO_TOP) is even, so the index keeps the address parity.
module regbank_xlat #(
    parameter int         AW       = 8,
    parameter int         LO_TOP   = 128,
    parameter int         HI_BASE  = 240,
    parameter int         N_PORT   = 4,
    parameter int         IDX_W    = 8,
    parameter logic [3:0] WORK_NIB = 4'hE
) (
    input  logic [AW-1:0]    addr,
    input  logic             short_sel,
    input  logic [AW-1:0]    ptr,
    output logic [AW-1:0]    phys,
    output logic             hit,
    output logic             is_port,
    output logic [IDX_W-1:0] idx
);
    // Expand the address and classify the region it lands in.
    always_comb begin
        if (short_sel || addr[AW-1:AW-4] == WORK_NIB) begin
            phys = {ptr[AW-1:AW-4], addr[3:0]};
        end else begin
            phys = addr;
        end
        hit     = (int'(phys) < LO_TOP) || (int'(phys) >= HI_BASE);
        is_port = int'(phys) < N_PORT;
        if (int'(phys) < LO_TOP) begin
            idx = IDX_W'(int'(phys));
        end else if (hit) begin
            idx = IDX_W'(int'(phys) - HI_BASE + LO_TOP);
        end else begin
            idx = '0;
        end
    end
endmodule

// File: rtl/regbank_bitop.sv
// In-place operation unit: bit test/set/clear/complement on one byte, and
// word increment/decrement on a high/low byte pair. Purely combinational.
// Assumes the caller gates writes with the target hit signal.
module regbank_bitop
    import regbank_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [2:0]      code,
    input  logic            hit,
    input  logic [2:0]      bsel,
    input  logic [W-1:0]    tgt_val,
    input  logic [W-1:0]    hi_val,
    input  logic [W-1:0]    lo_val,
    output logic            tg_we,
    output logic [W-1:0]    tg_new,
    output logic            pr_we,
    output logic [2*W-1:0]  pr_new,
    output logic            flag
);
    logic [W-1:0]   mask;
    logic [2*W-1:0] word;
    bitop_e         op;

    // Decode the operation and build the new values and the flag.
    always_comb begin
        op     = bitop_e'(code);
        mask   = W'(1) << bsel;
        word   = {hi_val, lo_val};
        tg_we  = 1'b0;
        tg_new = tgt_val;
        pr_we  = 1'b0;
        pr_new = word;
        flag   = tgt_val[bsel];
        case (op)
            OP_SET: begin
                tg_we  = hit;
                tg_new = tgt_val | mask;
            end
            OP_CLR: begin
                tg_we  = hit;
                tg_new = tgt_val & ~mask;
            end
            OP_CPL: begin
                tg_we  = hit;
                tg_new = tgt_val ^ mask;
            end
            OP_INCW: begin
                pr_we  = hit;
                pr_new = word + 1'b1;
                flag   = (word + 1'b1) == '0;
            end
            OP_DECW: begin
                pr_we  = hit;
                pr_new = word - 1'b1;
                flag   = (word - 1'b1) == '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regbank_store.sv
// Dense byte storage for every implemented location, with a synchronous
// active-low clear. Write-port data wins over operation results on the same
// byte. Assumes pr_idx is even; the low byte sits at pr_idx + 1.
module regbank_store #(
    parameter int N_LOC = 144,
    parameter int IDX_W = 8,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             tg_we,
    input  logic [IDX_W-1:0] tg_idx,
    input  logic [W-1:0]     tg_data,
    input  logic             pr_we,
    input  logic [IDX_W-1:0] pr_idx,
    input  logic [2*W-1:0]   pr_data,
    output logic [W-1:0]     cells [N_LOC]
);
    // Clear on reset, otherwise apply writes by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LOC; i++) cells[i] <= '0;
        end else begin
            for (int i = 0; i < N_LOC; i++) begin
                if (wr_we && int'(wr_idx) == i) begin
                    cells[i] <= wr_data;
                end else if (tg_we && int'(tg_idx) == i) begin
                    cells[i] <= tg_data;
                end else if (pr_we && int'(pr_idx) == i) begin
                    cells[i] <= pr_data[2*W-1:W];
                end else if (pr_we && int'(pr_idx) + 1 == i) begin
                    cells[i] <= pr_data[W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/regbank_top.sv
// Banked register file top: four address translators (read A, read B,
// write, operation), the storage, the operation unit and the read muxes with
// write-through bypass. Port registers read their pins and latch writes.
// Assumes the pointer lies in the high region.
module regbank_top
    import regbank_pkg::*;
#(
    parameter int LO_TOP   = 128,
    parameter int HI_BASE  = 240,
    parameter int N_PORT   = 4,
    parameter int PTR_ADDR = 253
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_a_addr,
    input  logic                 rd_a_short,
    output logic [DW-1:0]        rd_a_data,
    input  logic [AW-1:0]        rd_b_addr,
    input  logic                 rd_b_short,
    output logic [DW-1:0]        rd_b_data,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic                 wr_short,
    input  logic [DW-1:0]        wr_data,
    input  logic [2:0]           op_code,
    input  logic [AW-1:0]        op_addr,
    input  logic                 op_short,
    input  logic [2:0]           op_bit,
    output logic                 op_flag,
    input  logic [N_PORT*DW-1:0] port_in,
    output logic [N_PORT*DW-1:0] port_out
);
    localparam int N_LOC   = LO_TOP + (1 << AW) - HI_BASE;
    localparam int IDX_W   = $clog2(N_LOC);
    localparam int PTR_IDX = PTR_ADDR - HI_BASE + LO_TOP;
    localparam int N_CH    = 4;
    localparam int CH_WR   = 2;
    localparam int CH_OP   = 3;

    logic [DW-1:0]    cells [N_LOC];
    logic [AW-1:0]    ptr;
    logic [AW-1:0]    ch_addr  [N_CH];
    logic             ch_short [N_CH];
    logic [AW-1:0]    ch_phys  [N_CH];
    logic             ch_hit   [N_CH];
    logic             ch_port  [N_CH];
    logic [IDX_W-1:0] ch_idx   [N_CH];
    logic [DW-1:0]    rd_val   [2];

    logic             wr_go;
    logic [IDX_W-1:0] pr_idx;
    logic [DW-1:0]    op_tgt, op_hi, op_lo;
    logic             tg_we, pr_we;
    logic [DW-1:0]    tg_new;
    logic [2*DW-1:0]  pr_new;

    // Gather the four access channels into arrays.
    always_comb begin
        ch_addr[0]  = rd_a_addr;
        ch_short[0] = rd_a_short;
        ch_addr[1]  = rd_b_addr;
        ch_short[1] = rd_b_short;
        ch_addr[2]  = wr_addr;
        ch_short[2] = wr_short;
        ch_addr[3]  = op_addr;
        ch_short[3] = op_short;
    end

    assign ptr = cells[PTR_IDX];

    for (genvar g = 0; g < N_CH; g++) begin : g_xlat
        regbank_xlat #(
            .AW(AW), .LO_TOP(LO_TOP), .HI_BASE(HI_BASE),
            .N_PORT(N_PORT), .IDX_W(IDX_W)
        ) u_xlat (
            .addr     (ch_addr[g]),
            .short_sel(ch_short[g]),
            .ptr      (ptr),
            .phys     (ch_phys[g]),
            .hit      (ch_hit[g]),
            .is_port  (ch_port[g]),
            .idx      (ch_idx[g])
        );
    end

    assign wr_go  = wr_en && ch_hit[CH_WR];
    assign pr_idx = {ch_idx[CH_OP][IDX_W-1:1], 1'b0};

    // Fetch the operation operands from the latches and storage.
    always_comb begin
        if (ch_hit[CH_OP]) begin
            op_tgt = cells[ch_idx[CH_OP]];
            op_hi  = cells[pr_idx];
            op_lo  = cells[pr_idx | IDX_W'(1)];
        end else begin
            op_tgt = '0;
            op_hi  = '0;
            op_lo  = '0;
        end
    end

    regbank_bitop #(.W(DW)) u_bitop (
        .code   (op_code),
        .hit    (ch_hit[CH_OP]),
        .bsel   (op_bit),
        .tgt_val(op_tgt),
        .hi_val (op_hi),
        .lo_val (op_lo),
        .tg_we  (tg_we),
        .tg_new (tg_new),
        .pr_we  (pr_we),
        .pr_new (pr_new),
        .flag   (op_flag)
    );

    regbank_store #(.N_LOC(N_LOC), .IDX_W(IDX_W), .W(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_we  (wr_go),
        .wr_idx (ch_idx[CH_WR]),
        .wr_data(wr_data),
        .tg_we  (tg_we),
        .tg_idx (ch_idx[CH_OP]),
        .tg_data(tg_new),
        .pr_we  (pr_we),
        .pr_idx (pr_idx),
        .pr_data(pr_new),
        .cells  (cells)
    );

    for (genvar r = 0; r < 2; r++) begin : g_rd
        // Select the pin byte, the bypassed write data, storage or zero.
        always_comb begin
            if (ch_port[r]) begin
                rd_val[r] = port_in[int'(ch_phys[r]) * DW +: DW];
            end else if (wr_go && ch_hit[r] && ch_idx[r] == ch_idx[CH_WR]) begin
                rd_val[r] = wr_data;
            end else if (ch_hit[r]) begin
                rd_val[r] = cells[ch_idx[r]];
            end else begin
                rd_val[r] = '0;
            end
        end
    end

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];

    for (genvar p = 0; p < N_PORT; p++) begin : g_pout
        assign port_out[p*DW +: DW] = cells[p];
    end
endmodule

// File: rtl/regbank_chk.sv
// Property checker for regbank_top, attached by bind. Watches full-address
// accesses on read port A, the write port and the port latches.
module regbank_chk #(
    parameter int N_PORT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          rd_a_addr,
    input logic                rd_a_short,
    input logic [7:0]          rd_a_data,
    input logic                wr_en,
    input logic [7:0]          wr_addr,
    input logic                wr_short,
    input logic [7:0]          wr_data,
    input logic [2:0]          op_code,
    input logic [N_PORT*8-1:0] port_in,
    input logic [N_PORT*8-1:0] port_out
);
    // R3
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_short && rd_a_addr >= 8'h80 && rd_a_addr < 8'hE0) |-> rd_a_data == 8'h00);

    // R6
    port_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_short && int'(rd_a_addr) < N_PORT)
        |-> rd_a_data == port_in[int'(rd_a_addr) * 8 +: 8]);

    // R6
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_code == 3'd0) |=> $stable(port_out));

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_short && !rd_a_short && wr_addr == rd_a_addr
         && wr_addr >= 8'h04 && wr_addr < 8'h80) |-> rd_a_data == wr_data);

    // R2
    held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_short && rd_a_addr >= 8'h04 && rd_a_addr < 8'h80
         && $past(wr_en) && !$past(wr_short) && $past(wr_addr) == rd_a_addr
         && !(wr_en && wr_addr == rd_a_addr))
        |-> rd_a_data == $past(wr_data));
endmodule

bind regbank_top regbank_chk #(.N_PORT(N_PORT)) u_chk (.*);

// File: tb/sim_regbank_top.sv
// Scoreboard bench: the driver pushes expected values, the monitor compares
// them at the falling edge.
module sim_regbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0, wr_data = '0, op_addr = '0;
    logic        rd_a_short = 1'b0, rd_b_short = 1'b0, wr_short = 1'b0, op_short = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  op_code = '0, op_bit = '0;
    logic [31:0] port_in = 32'hA1B2C3D4;
    logic [7:0]  rd_a_data, rd_b_data;
    logic        op_flag;
    logic [31:0] port_out;

    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;
    string       q_tag [$];
    int          q_src [$];
    logic [7:0]  q_val [$];

    regbank_top u0 (.*);

    always #10 clk = ~clk;

    // src: 0 rd_a_data, 1 rd_b_data, 2 op_flag, 3..6 port_out byte 0..3
    task automatic expect_v(string tag, int src, logic [7:0] v);
        q_tag.push_back(tag);
        q_src.push_back(src);
        q_val.push_back(v);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0; op_code = 3'd0;
        rd_a_short = 1'b0; rd_b_short = 1'b0; wr_short = 1'b0; op_short = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic op(logic [2:0] c, logic [7:0] a, logic [2:0] b);
        op_code = c; op_addr = a; op_bit = b;
    endtask

    // Monitor: compare every queued expectation with the live outputs.
    always @(negedge clk) begin
        while (q_tag.size() > 0) begin
            string      t;
            int         s;
            logic [7:0] e, got;
            t = q_tag.pop_front();
            s = q_src.pop_front();
            e = q_val.pop_front();
            case (s)
                0:       got = rd_a_data;
                1:       got = rd_b_data;
                2:       got = {7'd0, op_flag};
                default: got = port_out[(s - 3) * 8 +: 8];
            endcase
            n_chk++;
            if (got !== e) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h", t, got, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_a_addr = 8'h10; rd_b_addr = 8'hFD;
        expect_v("R1 gp zero", 0, 8'h00);
        expect_v("R1 pointer zero", 1, 8'h00);
        expect_v("R1 port_out zero", 3, 8'h00);
        tick(); wr(8'h10, 8'h5A);
        tick(); wr(8'h7F, 8'hC3); rd_a_addr = 8'h10;
        expect_v("R2 read 0x10", 0, 8'h5A);
        tick(); wr(8'hF3, 8'h77);
        tick(); rd_a_addr = 8'hF3; rd_b_addr = 8'h7F;
        expect_v("R2 read 0xF3", 0, 8'h77);
        expect_v("R2 read 0x7F on B", 1, 8'hC3);
        // R7 bypass
        tick(); wr(8'h20, 8'h99); rd_a_addr = 8'h20; rd_b_addr = 8'h21;
        expect_v("R7 bypass", 0, 8'h99);
        expect_v("R7 neighbour", 1, 8'h00);
        // R3 unimplemented
        tick(); wr(8'h90, 8'hFF); rd_a_addr = 8'h90;
        expect_v("R3 same cycle zero", 0, 8'h00);
        tick(); rd_a_addr = 8'h90; rd_b_addr = 8'h10;
        expect_v("R3 reads zero", 0, 8'h00);
        expect_v("R3 no disturb", 1, 8'h5A);
        // R5 pointer write; same-cycle short read uses old pointer (group 0)
        tick(); wr(8'hFD, 8'h20); rd_a_addr = 8'h00; rd_a_short = 1'b1;
        expect_v("R5 old pointer", 0, 8'hD4);
        tick(); rd_a_addr = 8'h00; rd_a_short = 1'b1; rd_b_addr = 8'hE1;
        expect_v("R4 short r0 group 2", 0, 8'h99);
        expect_v("R4 0xE1 alias", 1, 8'h00);
        tick(); wr(8'h05, 8'h3C); wr_short = 1'b1; rd_a_addr = 8'hFD;
        expect_v("R5 pointer readback", 0, 8'h20);
        tick(); rd_a_addr = 8'h25;
        expect_v("R4 short write", 0, 8'h3C);
        tick(); op(3'd2, 8'h06, 3'd1); op_short = 1'b1;
        expect_v("R4 short op flag", 2, 8'h00);
        tick(); rd_a_addr = 8'h26;
        expect_v("R4 short op result", 0, 8'h02);
        // R6 ports
        tick(); rd_a_addr = 8'h00; rd_b_addr = 8'h03;
        expect_v("R6 pin 0", 0, 8'hD4);
        expect_v("R6 pin 3", 1, 8'hA1);
        tick(); wr(8'h02, 8'h6E); rd_a_addr = 8'h02;
        expect_v("R6 write reads pin", 0, 8'hB2);
        tick(); rd_a_addr = 8'h02;
        expect_v("R6 latch", 5, 8'h6E);
        expect_v("R6 still pin", 0, 8'hB2);
        // R8 bit operations
        tick(); wr(8'h30, 8'h0F);
        tick(); op(3'd2, 8'h30, 3'd7);
        expect_v("R8 set prior", 2, 8'h00);
        tick(); rd_a_addr = 8'h30; op(3'd1, 8'h30, 3'd0);
        expect_v("R8 set result", 0, 8'h8F);
        expect_v("R8 test bit0", 2, 8'h01);
        tick(); op(3'd3, 8'h30, 3'd0);
        expect_v("R8 clear prior", 2, 8'h01);
        tick(); rd_a_addr = 8'h30; op(3'd4, 8'h30, 3'd7);
        expect_v("R8 clear result", 0, 8'h8E);
        expect_v("R8 cpl prior", 2, 8'h01);
        tick(); rd_a_addr = 8'h30; op(3'd1, 8'h30, 3'd4);
        expect_v("R8 cpl result", 0, 8'h0E);
        expect_v("R8 test bit4", 2, 8'h00);
        // R10 write beats op
        tick(); wr(8'h30, 8'h55); op(3'd2, 8'h30, 3'd7);
        tick(); rd_a_addr = 8'h30;
        expect_v("R10 write wins", 0, 8'h55);
        // R9 word operations
        tick(); wr(8'h40, 8'h00);
        tick(); wr(8'h41, 8'hFF);
        tick(); op(3'd5, 8'h41, 3'd0);
        expect_v("R9 inc flag", 2, 8'h00);
        tick(); rd_a_addr = 8'h40; rd_b_addr = 8'h41; op(3'd6, 8'h40, 3'd0);
        expect_v("R9 inc hi", 0, 8'h01);
        expect_v("R9 inc lo", 1, 8'h00);
        expect_v("R9 dec flag", 2, 8'h00);
        tick(); rd_a_addr = 8'h40; rd_b_addr = 8'h41;
        expect_v("R9 dec hi", 0, 8'h00);
        expect_v("R9 dec lo", 1, 8'hFF);
        tick(); wr(8'h41, 8'h01);
        tick(); op(3'd6, 8'h40, 3'd0);
        expect_v("R9 dec to zero flag", 2, 8'h01);
        tick(); op(3'd6, 8'h40, 3'd0);
        expect_v("R9 wrap flag", 2, 8'h00);
        tick(); rd_a_addr = 8'h40; rd_b_addr = 8'h41; op(3'd5, 8'h41, 3'd0);
        expect_v("R9 wrap hi", 0, 8'hFF);
        expect_v("R9 wrap lo", 1, 8'hFF);
        expect_v("R9 inc wrap flag", 2, 8'h01);
        tick(); rd_a_addr = 8'h40; rd_b_addr = 8'h41;
        expect_v("R9 inc wrap hi", 0, 8'h00);
        expect_v("R9 inc wrap lo", 1, 8'h00);
        // R11 ops on port latches
        tick(); op(3'd2, 8'h02, 3'd0);
        expect_v("R11 set prior", 2, 8'h00);
        tick(); op(3'd1, 8'h00, 3'd2);
        expect_v("R11 latch", 5, 8'h6F);
        expect_v("R11 test uses latch", 2, 8'h00);
        tick();
        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule